// File: doc/BRIEF.md
# Radix-2 Carry-Save Modular Multiplier with Truncated Sign Estimation

This block computes a residue of A·B modulo an N-bit modulus M over N clock cycles. It takes one bit of the multiplier A per cycle, most significant bit first. The running result is held redundantly as a sum word and a carry word, so no full-width carry propagation ever sits in the loop.

In each cycle the block doubles the running result. Two short cascaded adders, working only on the bits at and above position EST_DROP, estimate the sign of that doubled value: first on its own, then shifted by ±3M. The pair of sign bits selects one correction from {−4M, −2M, +M, +4M}. That correction and the AND-gated partial product are merged into the doubled pair by two carry-save rows in the same cycle.

The result stays inside (−3M, 3M) and is congruent to A·B mod M. The final fold into [0, M) is left to the consumer. A start strobe latches A, B and M, and a one-cycle done flag marks the result.

Top module: `mm_r2_modmul`

## Requirements
- R1: A start_i sampled high at a rising edge latches a_i, b_i and m_i and clears both sum_o and carry_o to zero at that edge. A start_i during a running operation aborts it and begins a new one.
- R2: done_o is high for exactly one cycle, after the N-th rising edge that follows the edge which sampled start_i. It is low at every other time, including all cycles before that N-th edge.
- R3: With m_i[N-1]=1, b_i < m_i and EST_DROP ≤ N−3, the value V = signed(sum_o + carry_o), taken as a two's-complement number of N+4 bits, satisfies −3M < V < 3M after every iteration.
- R4: When done_o is high, V ≡ A·B (mod M). For A=187, B=221, M=239 this gives V mod 239 = 219.
- R5: Multiplier bits are consumed most significant first. After the k-th iteration, V ≡ (A >> (N−k))·B (mod M).
- R6: While no operation runs and start_i is low, sum_o and carry_o hold their value. Changes on a_i, b_i and m_i have no effect on them.
- R7: After reset, sum_o = 0, carry_o = 0 and done_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch operands and begin an operation |
| a_i | input | N | Multiplier, scanned MSB first |
| b_i | input | N | Multiplicand, expected below m_i |
| m_i | input | N | Modulus, MSB expected set |
| sum_o | output | N+4 | Sum word of the redundant result |
| carry_o | output | N+4 | Carry word of the redundant result |
| done_o | output | 1 | One-cycle flag that the result is complete |

## Verification
The assertions check several things on every cycle: that the redundant value stays inside (−3M, 3M), that a non-negative first estimate never hides a negative full-precision value, that done is a single-cycle pulse with the engine idle, that start clears the pair, and that the pair holds while idle. Congruence with A·B mod M can only be shown by the bench's scenarios, both after each iteration (the MSB-first prefix) and at completion. The same holds for the exact latency, for restart mid-operation, and for the insensitivity to operand changes while idle. The bench sweeps every 8-bit modulus with the top bit set against a set of operand pairs.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // {first sign negative, second sign negative}
  typedef enum logic [1:0] {
    CORR_SUB4 = 2'b00,
    CORR_SUB2 = 2'b01,
    CORR_ADD1 = 2'b10,
    CORR_ADD4 = 2'b11
  } corr_e;
endpackage

// File: rtl/mm_csa_row.sv
module mm_csa_row #(
  parameter int W = 12
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  assign carry_o[0] = cin_i;
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign sum_o[g] = x_i[g] ^ y_i[g] ^ z_i[g];
    if (g < W - 1) begin : g_cy
      assign carry_o[g+1] = (x_i[g] & y_i[g]) | (x_i[g] & z_i[g]) | (y_i[g] & z_i[g]);
    end
  end
endmodule

// File: rtl/mm_sign_est.sv
module mm_sign_est #(
  parameter int SW = 7
) (
  input  logic [SW-1:0] sum_hi_i,
  input  logic [SW-1:0] car_hi_i,
  input  logic [SW-1:0] m3_hi_i,
  output logic          neg1_o,
  output logic          neg2_o
);
  logic [SW-1:0] est1, est2;

  always_comb begin
    est1   = sum_hi_i + car_hi_i;
    neg1_o = est1[SW-1];
    est2   = neg1_o ? (est1 + m3_hi_i) : (est1 - m3_hi_i);
    neg2_o = est2[SW-1];
  end
endmodule

// File: rtl/mm_r2_modmul.sv
module mm_r2_modmul
  import mm_pkg::*;
#(
  parameter int N        = 8,
  parameter int EST_DROP = N - 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  input  logic [N-1:0]   m_i,
  output logic [N+3:0]   sum_o,
  output logic [N+3:0]   carry_o,
  output logic           done_o
);
  localparam int W  = N + 4;
  localparam int SW = W - EST_DROP;
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  a_sh, b_q, m_q;
  logic [W-1:0]  s_q, c_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  logic [W-1:0]  s2, c2, pp, mw, corr_mag, corr;
  logic [W-1:0]  r1_s, r1_c, nxt_s, nxt_c;
  logic [SW-1:0] m3_hi;
  logic          neg1, neg2;
  corr_e         sel;

  assign s2 = s_q << 1;
  assign c2 = c_q << 1;
  assign mw = {{(W-N){1'b0}}, m_q};
  assign pp = {{(W-N){1'b0}}, b_q} & {W{a_sh[N-1]}};
  // truncated 3M built from T(M)+T(2M)
  assign m3_hi = SW'(mw >> EST_DROP) + SW'((mw << 1) >> EST_DROP);

  mm_sign_est #(.SW(SW)) u_est (
    .sum_hi_i (SW'(s2 >> EST_DROP)),
    .car_hi_i (SW'(c2 >> EST_DROP)),
    .m3_hi_i  (m3_hi),
    .neg1_o   (neg1),
    .neg2_o   (neg2)
  );

  always_comb begin
    sel = corr_e'({neg1, neg2});
    unique case (sel)
      CORR_SUB2: corr_mag = mw << 1;
      CORR_ADD1: corr_mag = mw;
      default:   corr_mag = mw << 2;
    endcase
    // first sign non-negative: subtract via inversion, +1 enters carry lsb
    corr = neg1 ? corr_mag : ~corr_mag;
  end

  mm_csa_row #(.W(W)) u_row_pp (
    .x_i(s2), .y_i(c2), .z_i(pp), .cin_i(1'b0),
    .sum_o(r1_s), .carry_o(r1_c)
  );

  mm_csa_row #(.W(W)) u_row_mod (
    .x_i(r1_s), .y_i(r1_c), .z_i(corr), .cin_i(~neg1),
    .sum_o(nxt_s), .carry_o(nxt_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh   <= '0;
      b_q    <= '0;
      m_q    <= '0;
      s_q    <= '0;
      c_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      a_sh   <= a_i;
      b_q    <= b_i;
      m_q    <= m_i;
      s_q    <= '0;
      c_q    <= '0;
      cnt_q  <= CW'(N);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      a_sh   <= a_sh << 1;
      s_q    <= nxt_s;
      c_q    <= nxt_c;
      cnt_q  <= cnt_q - 1'b1;
      busy_q <= (cnt_q != CW'(1));
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign sum_o   = s_q;
  assign carry_o = c_q;
  assign done_o  = done_q;

  // checks
  logic [W-1:0]          tot;
  logic signed [W+1:0]   val_x, mx, lim;
  logic [W-1:0]          tot2;
  assign tot   = s_q + c_q;
  assign tot2  = s2 + c2;
  assign val_x = {{2{tot[W-1]}}, tot};
  assign mx    = {{(W+2-N){1'b0}}, m_q};
  assign lim   = mx + (mx <<< 1);

  p_start_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (s_q == '0) && (c_q == '0) && busy_q);

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((busy_q || done_q) && m_q[N-1]) |-> ((val_x > -lim) && (val_x < lim)));

  p_est_sound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !neg1) |-> !tot2[W-1]);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(s_q) && $stable(c_q)));
endmodule

// File: tb/mm_r2_modmul_bench.sv
`timescale 1ns/1ps
module mm_r2_modmul_bench;
  localparam int N = 8;
  localparam int W = N + 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [N-1:0] a_i = '0, b_i = '0, m_i = '0;
  logic [W-1:0] sum_o, carry_o;
  logic         done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  mm_r2_modmul #(.N(N), .EST_DROP(N-3)) u_mm_r2_modmul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .m_i(m_i),
    .sum_o(sum_o), .carry_o(carry_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint cur_val();
    logic [W-1:0] t;
    t = sum_o + carry_o;
    return longint'($signed(t));
  endfunction

  function automatic longint md(input longint x, input longint m);
    return ((x % m) + m) % m;
  endfunction

  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic begin_op(input int a, input int b, input int m);
    @(negedge clk);
    a_i = N'(a); b_i = N'(b); m_i = N'(m); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(sum_o == '0 && carry_o == '0, "R1", longint'(sum_o | carry_o), 0);
  endtask

  task automatic finish_op(input int a, input int b, input int m, output longint v);
    for (int k = 1; k <= N; k++) begin
      longint x, pre;
      @(negedge clk);
      x   = cur_val();
      pre = longint'(a >> (N - k)) * b;
      check(md(x, m) == md(pre, m), "R5", md(x, m), md(pre, m));
      check(x > -3 * longint'(m) && x < 3 * longint'(m), "R3", x, m);
      check(done_o == (k == N), "R2", done_o, (k == N));
    end
    v = cur_val();
    check(md(v, m) == md(longint'(a) * b, m), "R4", md(v, m), md(longint'(a) * b, m));
    // idle: scramble operands, result must hold
    a_i = ~a_i; b_i = ~b_i; m_i = ~m_i;
    @(negedge clk);
    check(done_o == 1'b0, "R2", done_o, 0);
    check(cur_val() == v, "R6", cur_val(), v);
  endtask

  initial begin
    longint v;
    #20;
    check(sum_o == '0 && carry_o == '0 && done_o == 1'b0, "R7",
          longint'(sum_o | carry_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // worked example
    begin_op(187, 221, 239);
    finish_op(187, 221, 239, v);
    check(md(v, 239) == 219, "R4", md(v, 239), 219);

    // corner operands
    begin_op(255, 254, 255);
    finish_op(255, 254, 255, v);
    begin_op(0, 100, 128);
    finish_op(0, 100, 128, v);
    begin_op(255, 127, 128);
    finish_op(255, 127, 128, v);

    // restart while busy: first op aborted after three iterations
    begin_op(200, 50, 211);
    repeat (3) begin
      @(negedge clk);
      check(done_o == 1'b0, "R2", done_o, 0);
    end
    begin_op(77, 190, 193);
    finish_op(77, 190, 193, v);
    check(md(v, 193) == md(77 * 190, 193), "R1", md(v, 193), md(77 * 190, 193));

    // sweep every modulus with top bit set
    for (int m = 128; m < 256; m++) begin
      for (int j = 0; j < 12; j++) begin
        int a, b;
        a = int'(nxt() % 256);
        b = int'(nxt() % m);
        if (j == 0) begin a = 255; b = m - 1; end
        if (j == 1) begin a = 128; b = 1; end
        begin_op(a, b, m);
        finish_op(a, b, m, v);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 180000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule